// File: doc/BRIEF.md
# Raw-Frame Socket Buffer Controller

This block runs a single raw-Ethernet socket for a host processor. The host sees a byte-wide map with three windows: a small socket register window, a transmit ring and a receive ring. The host writes outgoing frame bytes into the transmit ring, moves the transmit write pointer and issues SEND. The block then streams those bytes to a frame-output port and raises a send-complete flag. Frames from an input stream are written into the receive ring, each behind a length prefix. The host learns the pending byte count, reads the frame, moves its read pointer and issues RECV to hand the space back.

All pointers are free-running 16-bit counters. The physical ring location of a pointer is its value modulo the ring size, so every access wraps at the ring end without any host arithmetic. Commands are written to a command register. The register reads back zero once the block has taken the command, and the host polls it for that zero. Each ring holds 2^BUF_AW bytes; the ring bases and the register window base are parameters.

Top module: `rawsock_ctrl`

## Requirements
- R1: A write to the command register is taken only while it reads 0. OPEN, CLOSE, RECV and unknown codes read back 0 one cycle after being taken. SEND (0x20) reads back 0x20 until its frame has been fully emitted, and then 0.
- R2: OPEN (0x01) sets status to 0x42 when the mode register holds 0x04 (raw) or 0x44 (raw, filtered); with any other mode the status stays 0x00.
- R3: CLOSE (0x10) sets status to 0x00 and sets the TX read, TX write, RX read and released pointers and the internal RX write pointer to zero.
- R4: Register window offsets: 0 mode, 1 command, 2 interrupt, 3 status, 4/5 TX free, 6/7 TX read, 8/9 TX write, 10/11 RX size, 12/13 RX read; 16-bit values are high byte first. TX free reads 2^BUF_AW − (TX write − TX read) mod 2^16.
- R5: SEND with the socket open emits the bytes at TX_BASE + (p mod 2^BUF_AW) for p from the TX read to the TX write pointer, one per cycle with out_valid, marking only the final byte with out_last. Afterwards TX read equals TX write.
- R6: SEND with equal pointers emits nothing but still sets send-complete. SEND while the status is not 0x42 emits nothing and sets no flag.
- R7: Interrupt bit 4 (0x10) flags send complete and bit 2 (0x04) flags a received frame. Writing ones to the interrupt register clears those bits, a set in the same cycle wins, and irq is high while any flag is set.
- R8: An accepted frame of N bytes is stored from RX_BASE + (w mod 2^BUF_AW), where w is the RX write pointer. The first two bytes hold N+2, high byte first, and the N data bytes follow. Every byte wraps modulo the ring size.
- R9: RX size reads (RX write − released pointer). A host write to the RX read pointer does not change it; RECV (0x40) copies the RX read pointer into the released pointer.
- R10: A frame that does not fit in the free RX space (2^BUF_AW − RX size), counting its two length bytes, is dropped whole. A frame arriving while the status is not 0x42 is also dropped. A dropped frame leaves every pointer and flag unchanged.
- R11: in_ready is high while the block takes frame bytes and low for the two cycles after the last byte of an accepted frame, while the length prefix is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| in_valid | input | 1 | Incoming frame byte valid |
| in_data | input | 8 | Incoming frame byte |
| in_last | input | 1 | Marks last byte of incoming frame |
| in_ready | output | 1 | Block accepts an incoming byte |
| out_valid | output | 1 | Outgoing frame byte valid |
| out_data | output | 8 | Outgoing frame byte |
| out_last | output | 1 | Marks last byte of outgoing frame |
| irq | output | 1 | High while any interrupt flag is set |

## Verification
The bench builds the block with BUF_AW = 6, a 64-byte ring for each direction, and keeps the default window bases. With rings that small, a few short frames push both pointers across the ring end. A transmit frame straddling the wrap and a receive frame whose length prefix sits at the ring end are then checked byte by byte. The same size lets the tests fill the receive ring exactly, drop an oversized frame, and drop a frame one byte too large for the remaining space.

// File: rtl/rawsock_pkg.sv
package rawsock_pkg;

    localparam logic [7:0] CMD_OPEN  = 8'h01;
    localparam logic [7:0] CMD_CLOSE = 8'h10;
    localparam logic [7:0] CMD_SEND  = 8'h20;
    localparam logic [7:0] CMD_RECV  = 8'h40;

    localparam int FLAG_SENT = 4;
    localparam int FLAG_RCVD = 2;
    localparam logic [7:0] FLAG_MASK = 8'h14;

    localparam logic [7:0] MODE_RAW      = 8'h04;
    localparam logic [7:0] MODE_RAW_FILT = 8'h44;
    localparam logic [7:0] STAT_CLOSED   = 8'h00;
    localparam logic [7:0] STAT_RAW      = 8'h42;

    localparam logic [3:0] OFS_MODE    = 4'd0;
    localparam logic [3:0] OFS_CMD     = 4'd1;
    localparam logic [3:0] OFS_IRQ     = 4'd2;
    localparam logic [3:0] OFS_STATUS  = 4'd3;
    localparam logic [3:0] OFS_TXFREE  = 4'd4;
    localparam logic [3:0] OFS_TXRD    = 4'd6;
    localparam logic [3:0] OFS_TXWR    = 4'd8;
    localparam logic [3:0] OFS_RXSIZE  = 4'd10;
    localparam logic [3:0] OFS_RXRD    = 4'd12;

    typedef enum logic {TX_IDLE, TX_RUN} tx_state_e;
    typedef enum logic [1:0] {RX_BODY, RX_HDR_HI, RX_HDR_LO} rx_state_e;

    // Byte lane of a 16-bit register; even offset carries the high byte.
    function automatic logic [7:0] pick_byte(input logic [15:0] v, input logic lo_lane);
        return lo_lane ? v[7:0] : v[15:8];
    endfunction

    // Replace one byte lane of a 16-bit register.
    function automatic logic [15:0] put_byte(input logic [15:0] v, input logic lo_lane,
                                             input logic [7:0] b);
        return lo_lane ? {v[15:8], b} : {b, v[7:0]};
    endfunction

    function automatic logic is_raw_mode(input logic [7:0] m);
        return (m == MODE_RAW) || (m == MODE_RAW_FILT);
    endfunction

endpackage

// File: rtl/rawsock_ring_mem.sv
module rawsock_ring_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ridx,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/rawsock_tx_engine.sv
module rawsock_tx_engine
    import rawsock_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          start,
    input  logic [15:0]   wr_ptr,
    output logic [15:0]   rd_ptr,
    output logic [AW-1:0] mem_idx,
    input  logic [7:0]    mem_data,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_last,
    output logic          done
);
    tx_state_e   state;
    logic [15:0] end_ptr;
    logic [15:0] rd_next;

    assign rd_next   = rd_ptr + 16'd1;
    assign mem_idx   = rd_ptr[AW-1:0];
    assign out_valid = (state == TX_RUN);
    assign out_data  = mem_data;
    assign out_last  = (state == TX_RUN) && (rd_next == end_ptr);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state   <= TX_IDLE;
            rd_ptr  <= '0;
            end_ptr <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        if (wr_ptr == rd_ptr) begin
                            done <= 1'b1;
                        end else begin
                            end_ptr <= wr_ptr;
                            state   <= TX_RUN;
                        end
                    end
                end
                TX_RUN: begin
                    rd_ptr <= rd_next;
                    if (rd_next == end_ptr) begin
                        state <= TX_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R5: the final byte ends the frame and leaves the read pointer at the frame end
    assert_frame_end_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last && !clear) |=> (!out_valid && done && rd_ptr == $past(end_ptr)));
endmodule

// File: rtl/rawsock_rx_writer.sv
module rawsock_rx_writer
    import rawsock_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          open,
    input  logic [15:0]   rel_ptr,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic [15:0]   wr_ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_idx,
    output logic [7:0]    mem_data,
    output logic          frame_done
);
    localparam int RING = 2 ** AW;

    rx_state_e   state;
    logic [15:0] cnt;
    logic [15:0] hdr_len;
    logic        dropping;
    logic [15:0] used;
    logic        fits_next;
    logic        accept;
    logic        byte_ok;

    assign used      = wr_ptr - rel_ptr;
    assign fits_next = ({2'b00, used} + {2'b00, cnt} + 18'd3) <= 18'(RING);
    assign in_ready  = (state == RX_BODY);
    assign accept    = in_valid && in_ready;
    assign byte_ok   = open && !dropping && fits_next;

    always_comb begin
        mem_we   = 1'b0;
        mem_idx  = AW'(wr_ptr + 16'd2 + cnt);
        mem_data = in_data;
        case (state)
            RX_BODY: mem_we = accept && byte_ok;
            RX_HDR_HI: begin
                mem_we   = 1'b1;
                mem_idx  = AW'(wr_ptr);
                mem_data = hdr_len[15:8];
            end
            RX_HDR_LO: begin
                mem_we   = 1'b1;
                mem_idx  = AW'(wr_ptr + 16'd1);
                mem_data = hdr_len[7:0];
            end
            default: mem_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state      <= RX_BODY;
            cnt        <= '0;
            hdr_len    <= '0;
            dropping   <= 1'b0;
            wr_ptr     <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (state)
                RX_BODY: begin
                    if (accept) begin
                        if (in_last) begin
                            cnt      <= '0;
                            dropping <= 1'b0;
                            if (byte_ok) begin
                                hdr_len <= cnt + 16'd3;
                                state   <= RX_HDR_HI;
                            end
                        end else if (byte_ok) begin
                            cnt <= cnt + 16'd1;
                        end else begin
                            dropping <= 1'b1;
                        end
                    end
                end
                RX_HDR_HI: state <= RX_HDR_LO;
                RX_HDR_LO: begin
                    wr_ptr     <= wr_ptr + hdr_len;
                    frame_done <= 1'b1;
                    state      <= RX_BODY;
                end
                default: state <= RX_BODY;
            endcase
        end
    end

    // R10: a frame rejected at its last byte leaves the write pointer where it was
    assert_drop_keeps_ptr_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && in_last && !byte_ok && !clear) |=> (wr_ptr == $past(wr_ptr)));

    // R8: committing a frame advances the write pointer by the stored length
    assert_commit_len_R8: assert property (@(posedge clk) disable iff (rst)
        (state == RX_HDR_LO && !clear) |=> (frame_done && wr_ptr == $past(wr_ptr) + $past(hdr_len)));

    // R11: no byte is taken while the prefix is written
    assert_prefix_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (state == RX_HDR_HI && !clear) |=> !in_ready);
endmodule

// File: rtl/rawsock_ctrl.sv
module rawsock_ctrl
    import rawsock_pkg::*;
#(
    parameter int          BUF_AW   = 10,
    parameter logic [15:0] REG_BASE = 16'h4000,
    parameter logic [15:0] TX_BASE  = 16'h8000,
    parameter logic [15:0] RX_BASE  = 16'hC000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] host_addr,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        irq
);
    localparam int          RING      = 2 ** BUF_AW;
    localparam logic [15:0] RING_SIZE = 16'(RING);

    logic [7:0]  mode_q, cmd_q, status_q, irq_q, irq_d;
    logic [15:0] tx_wr_q, rx_rd_q, rx_rel_q;
    logic        send_wait_q, send_go_q;

    logic [15:0] reg_off, tx_off, rx_off;
    logic        reg_hit, tx_hit, rx_hit, reg_wr;
    logic        clear, sock_open;

    logic [15:0] tx_rd, rx_wr, tx_free, rx_size;
    logic        tx_done, rx_done;
    logic [BUF_AW-1:0] tx_ridx;
    logic [7:0]        tx_rdata, rx_rdata;
    logic              rx_we;
    logic [BUF_AW-1:0] rx_widx;
    logic [7:0]        rx_wdata;

    // Address decode
    assign reg_off = host_addr - REG_BASE;
    assign tx_off  = host_addr - TX_BASE;
    assign rx_off  = host_addr - RX_BASE;
    assign reg_hit = reg_off < 16'd16;
    assign tx_hit  = tx_off < RING_SIZE;
    assign rx_hit  = rx_off < RING_SIZE;
    assign reg_wr  = host_wr && reg_hit;

    assign clear     = (cmd_q == CMD_CLOSE);
    assign sock_open = (status_q == STAT_RAW);
    assign tx_free   = RING_SIZE - (tx_wr_q - tx_rd);
    assign rx_size   = rx_wr - rx_rel_q;
    assign irq       = |irq_q;

    rawsock_ring_mem #(.AW(BUF_AW)) u_tx_mem (
        .clk   (clk),
        .we    (host_wr && tx_hit),
        .widx  (tx_off[BUF_AW-1:0]),
        .wdata (host_wdata),
        .ridx  (tx_ridx),
        .rdata (tx_rdata)
    );

    rawsock_ring_mem #(.AW(BUF_AW)) u_rx_mem (
        .clk   (clk),
        .we    (rx_we),
        .widx  (rx_widx),
        .wdata (rx_wdata),
        .ridx  (rx_off[BUF_AW-1:0]),
        .rdata (rx_rdata)
    );

    rawsock_tx_engine #(.AW(BUF_AW)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .start     (send_go_q),
        .wr_ptr    (tx_wr_q),
        .rd_ptr    (tx_rd),
        .mem_idx   (tx_ridx),
        .mem_data  (tx_rdata),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .done      (tx_done)
    );

    rawsock_rx_writer #(.AW(BUF_AW)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .open       (sock_open),
        .rel_ptr    (rx_rel_q),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .wr_ptr     (rx_wr),
        .mem_we     (rx_we),
        .mem_idx    (rx_widx),
        .mem_data   (rx_wdata),
        .frame_done (rx_done)
    );

    // Interrupt flags: write-one-to-clear, set has priority
    always_comb begin
        irq_d = irq_q;
        if (reg_wr && reg_off[3:0] == OFS_IRQ) begin
            irq_d = irq_d & ~host_wdata;
        end
        if (tx_done) irq_d[FLAG_SENT] = 1'b1;
        if (rx_done) irq_d[FLAG_RCVD] = 1'b1;
        irq_d = irq_d & FLAG_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            cmd_q       <= '0;
            status_q    <= STAT_CLOSED;
            irq_q       <= '0;
            tx_wr_q     <= '0;
            rx_rd_q     <= '0;
            rx_rel_q    <= '0;
            send_wait_q <= 1'b0;
            send_go_q   <= 1'b0;
        end else begin
            irq_q     <= irq_d;
            send_go_q <= 1'b0;

            if (reg_wr) begin
                case (reg_off[3:0])
                    OFS_MODE: mode_q <= host_wdata;
                    OFS_CMD:  if (cmd_q == 8'h00) cmd_q <= host_wdata;
                    OFS_TXWR, OFS_TXWR + 4'd1:
                        tx_wr_q <= put_byte(tx_wr_q, reg_off[0], host_wdata);
                    OFS_RXRD, OFS_RXRD + 4'd1:
                        rx_rd_q <= put_byte(rx_rd_q, reg_off[0], host_wdata);
                    default: ;
                endcase
            end

            if (cmd_q != 8'h00) begin
                case (cmd_q)
                    CMD_OPEN: begin
                        status_q <= is_raw_mode(mode_q) ? STAT_RAW : STAT_CLOSED;
                        cmd_q    <= '0;
                    end
                    CMD_CLOSE: begin
                        status_q <= STAT_CLOSED;
                        tx_wr_q  <= '0;
                        rx_rd_q  <= '0;
                        rx_rel_q <= '0;
                        cmd_q    <= '0;
                    end
                    CMD_SEND: begin
                        if (!send_wait_q) begin
                            if (sock_open) begin
                                send_go_q   <= 1'b1;
                                send_wait_q <= 1'b1;
                            end else begin
                                cmd_q <= '0;
                            end
                        end else if (tx_done) begin
                            send_wait_q <= 1'b0;
                            cmd_q       <= '0;
                        end
                    end
                    CMD_RECV: begin
                        rx_rel_q <= rx_rd_q;
                        cmd_q    <= '0;
                    end
                    default: cmd_q <= '0;
                endcase
            end
        end
    end

    // Host read path
    always_comb begin
        host_rdata = 8'h00;
        if (reg_hit) begin
            case (reg_off[3:1])
                3'd0: host_rdata = reg_off[0] ? cmd_q : mode_q;
                3'd1: host_rdata = reg_off[0] ? status_q : irq_q;
                3'd2: host_rdata = pick_byte(tx_free, reg_off[0]);
                3'd3: host_rdata = pick_byte(tx_rd, reg_off[0]);
                3'd4: host_rdata = pick_byte(tx_wr_q, reg_off[0]);
                3'd5: host_rdata = pick_byte(rx_size, reg_off[0]);
                3'd6: host_rdata = pick_byte(rx_rd_q, reg_off[0]);
                default: host_rdata = 8'h00;
            endcase
        end else if (rx_hit) begin
            host_rdata = rx_rdata;
        end
    end

    // R1: every command other than SEND is acknowledged on the next cycle
    assert_cmd_ack_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != 8'h00 && cmd_q != CMD_SEND) |=> (cmd_q == 8'h00));

    // R2: OPEN in a raw mode reaches the raw-open status
    assert_open_raw_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_OPEN && is_raw_mode(mode_q)) |=> (status_q == STAT_RAW));

    // R3: CLOSE zeroes the status and every pointer, including those in the engines
    assert_close_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_CLOSE) |=> (status_q == STAT_CLOSED && tx_wr_q == 16'h0 &&
                                  tx_rd == 16'h0 && rx_wr == 16'h0 && rx_rel_q == 16'h0));

    // R7: a finished transmission always leaves the send-complete flag set
    assert_sent_flag_R7: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> irq_q[FLAG_SENT]);
endmodule

// File: tb/tb_rawsock_ctrl.sv
module tb_rawsock_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 6;
    localparam int RING = 64;
    localparam logic [15:0] RB = 16'h4000;
    localparam logic [15:0] TB = 16'h8000;
    localparam logic [15:0] XB = 16'hC000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] cap [256];
    logic       cap_last [256];
    int         cap_n = 0;
    logic       ready_after_last;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rawsock_ctrl #(.BUF_AW(AW)) dut (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .irq(irq)
    );

    always @(negedge clk) begin
        if (out_valid && cap_n < 256) begin
            cap[cap_n]      = out_data;
            cap_last[cap_n] = out_last;
            cap_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b0; host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic rd16(input logic [15:0] a, output logic [15:0] v);
        logic [7:0] h, l;
        rd(a, h);
        rd(a + 16'd1, l);
        v = {h, l};
    endtask

    task automatic wr16(input logic [15:0] a, input logic [15:0] v);
        wr(a, v[15:8]);
        wr(a + 16'd1, v[7:0]);
    endtask

    task automatic do_cmd(input logic [7:0] code);
        logic [7:0] c;
        wr(RB + 16'd1, code);
        for (int i = 0; i < 2000; i++) begin
            rd(RB + 16'd1, c);
            if (c == 8'h00) break;
        end
    endtask

    task automatic feed(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 8'(i);
            in_last  = (i == len - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        ready_after_last = in_ready;
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] b; logic [15:0] v;
        rd(RB + 16'd1, b);  chk("R1 reset cmd", b, 0);
        rd(RB + 16'd3, b);  chk("R3 reset status", b, 0);
        rd16(RB + 16'd4, v); chk("R4 reset tx free", v, RING);
        rd16(RB + 16'd10, v); chk("R9 reset rx size", v, 0);
        chk("R11 reset in_ready", in_ready, 1);
        chk("R5 reset out_valid", out_valid, 0);
        chk("R7 reset irq", irq, 0);
    endtask

    task automatic t_open;
        logic [7:0] b;
        wr(RB, 8'h00);
        do_cmd(8'h01);
        rd(RB + 16'd3, b); chk("R2 open non-raw", b, 8'h00);
        wr(RB, 8'h04);
        do_cmd(8'h01);
        rd(RB + 16'd3, b); chk("R2 open raw", b, 8'h42);
        rd(RB + 16'd1, b); chk("R1 open acked", b, 8'h00);
    endtask

    task automatic t_send;
        logic [7:0] b; logic [15:0] v; int lastc;
        for (int i = 0; i < 10; i++) wr(TB + 16'(i), 8'hA0 + 8'(i));
        wr16(RB + 16'd8, 16'd10);
        rd16(RB + 16'd4, v); chk("R4 tx free after write", v, RING - 10);
        cap_n = 0;
        wr(RB + 16'd1, 8'h20);
        rd(RB + 16'd1, b); chk("R1 send pending", b, 8'h20);
        do_cmd(8'h00);
        for (int i = 0; i < 2000; i++) begin rd(RB + 16'd1, b); if (b == 0) break; end
        chk("R5 send count", cap_n, 10);
        lastc = 0;
        for (int i = 0; i < 10; i++) begin
            chk("R5 send byte", cap[i], 8'hA0 + 8'(i));
            lastc += int'(cap_last[i]);
        end
        chk("R5 single last", lastc, 1);
        chk("R5 last position", cap_last[9], 1);
        rd16(RB + 16'd6, v); chk("R5 tx read after send", v, 10);
        rd16(RB + 16'd4, v); chk("R4 tx free after send", v, RING);
        rd(RB + 16'd2, b); chk("R7 send flag", b, 8'h10);
        chk("R7 irq pin", irq, 1);
        wr(RB + 16'd2, 8'h10);
        rd(RB + 16'd2, b); chk("R7 clear flag", b, 8'h00);
    endtask

    task automatic t_wrap_send;
        logic [7:0] b; logic [15:0] v;
        wr16(RB + 16'd8, 16'd60);
        cap_n = 0;
        do_cmd(8'h20);
        chk("R5 long send count", cap_n, 50);
        for (int i = 0; i < 8; i++) wr(TB + 16'((60 + i) % RING), 8'h30 + 8'(i));
        wr16(RB + 16'd8, 16'd68);
        cap_n = 0;
        do_cmd(8'h20);
        chk("R5 wrap send count", cap_n, 8);
        for (int i = 0; i < 8; i++) chk("R5 wrap send byte", cap[i], 8'h30 + 8'(i));
        chk("R5 wrap last", cap_last[7], 1);
        rd16(RB + 16'd6, v); chk("R5 tx read after wrap", v, 68);
        wr(RB + 16'd2, 8'hFF);
        cap_n = 0;
        do_cmd(8'h20);
        chk("R6 empty send no output", cap_n, 0);
        rd(RB + 16'd2, b); chk("R6 empty send flag", b, 8'h10);
        wr(RB + 16'd2, 8'hFF);
    endtask

    task automatic t_rx;
        logic [7:0] b; logic [15:0] v;
        feed(5, 8'h50);
        chk("R11 ready low after last", ready_after_last, 0);
        rd16(RB + 16'd10, v); chk("R9 rx size", v, 7);
        rd(XB, b);            chk("R8 len high", b, 8'h00);
        rd(XB + 16'd1, b);    chk("R8 len low", b, 8'h07);
        rd(XB + 16'd2, b);    chk("R8 first body", b, 8'h50);
        rd(XB + 16'd6, b);    chk("R8 last body", b, 8'h54);
        rd(RB + 16'd2, b);    chk("R7 recv flag", b, 8'h04);
        wr16(RB + 16'd12, 16'd7);
        rd16(RB + 16'd10, v); chk("R9 size held before RECV", v, 7);
        do_cmd(8'h40);
        rd16(RB + 16'd10, v); chk("R9 size after RECV", v, 0);
        wr(RB + 16'd2, 8'hFF);
    endtask

    task automatic t_drop;
        logic [7:0] b; logic [15:0] v;
        feed(70, 8'h00);
        rd16(RB + 16'd10, v); chk("R10 oversize dropped", v, 0);
        rd(RB + 16'd2, b);    chk("R10 no flag on drop", b, 8'h00);
        feed(50, 8'h10);
        rd16(RB + 16'd10, v); chk("R9 size after 50", v, 52);
        feed(11, 8'hE0);
        rd16(RB + 16'd10, v); chk("R10 one-too-many dropped", v, 52);
        feed(10, 8'h70);
        rd16(RB + 16'd10, v); chk("R10 exact fill", v, 64);
        rd(XB + 16'd59, b);   chk("R8 hdr at ring end", b, 8'h00);
        rd(XB + 16'd60, b);   chk("R8 hdr low at ring end", b, 8'h0C);
        rd(XB + 16'd63, b);   chk("R8 body before wrap", b, 8'h72);
        rd(XB, b);            chk("R8 body after wrap", b, 8'h73);
    endtask

    task automatic t_close;
        logic [7:0] b; logic [15:0] v;
        do_cmd(8'h10);
        rd(RB + 16'd3, b);    chk("R3 status closed", b, 8'h00);
        rd16(RB + 16'd6, v);  chk("R3 tx read zero", v, 0);
        rd16(RB + 16'd8, v);  chk("R3 tx write zero", v, 0);
        rd16(RB + 16'd10, v); chk("R3 rx size zero", v, 0);
        rd16(RB + 16'd12, v); chk("R3 rx read zero", v, 0);
        feed(4, 8'h20);
        rd16(RB + 16'd10, v); chk("R10 closed frame dropped", v, 0);
        wr(RB + 16'd2, 8'hFF);
        wr16(RB + 16'd8, 16'd3);
        cap_n = 0;
        do_cmd(8'h20);
        chk("R6 closed send no output", cap_n, 0);
        rd(RB + 16'd2, b);    chk("R6 closed send no flag", b, 8'h00);
        rd16(RB + 16'd6, v);  chk("R6 closed send tx read", v, 0);
    endtask

    task automatic t_busy;
        logic [7:0] b;
        wr(RB, 8'h44);
        do_cmd(8'h01);
        rd(RB + 16'd3, b); chk("R2 open raw filtered", b, 8'h42);
        wr16(RB + 16'd8, 16'd40);
        cap_n = 0;
        wr(RB + 16'd1, 8'h20);
        wr(RB + 16'd1, 8'h10);
        rd(RB + 16'd1, b); chk("R1 busy cmd holds send", b, 8'h20);
        do_cmd(8'h00);
        for (int i = 0; i < 2000; i++) begin rd(RB + 16'd1, b); if (b == 0) break; end
        rd(RB + 16'd3, b); chk("R1 close ignored while busy", b, 8'h42);
        chk("R5 busy send count", cap_n, 40);
        feed(3, 8'h90);
        rd(RB + 16'd2, b); chk("R7 both flags", b, 8'h14);
        wr(RB + 16'd2, 8'h04);
        rd(RB + 16'd2, b); chk("R7 partial clear", b, 8'h10);
        chk("R7 irq pin partial", irq, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_open;
        t_send;
        t_wrap_send;
        t_rx;
        t_drop;
        t_close;
        t_busy;
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule